// File: doc/BRIEF.md
# Data Cache Line Maintenance Unit

This block executes one maintenance command against a direct-mapped data cache. A command can write a line back to memory, invalidate it, or do both. The command carries two 32-bit operands and four option flags: a match-only flag, an AND-address flag, an external flag and a write-back flag. A user-mode flag comes with the command. From the operands the block forms a target address, then splits it into a line index and a line-aligned base address. It reads that entry from a local model of the tag and data arrays.

A dirty line that is being flushed sends its valid words to memory, one word per valid/ready transfer. After that the entry is cleared, either always or only when its stored line address matches. When the external flag is set, the block also issues a one-cycle request carrying the target address to an outer cache. A command issued in user mode changes nothing and reports a privileged-instruction exception.

The tag array model has a fill port and a probe port. The surrounding pipeline, or a testbench, uses them to load entries and inspect them. The `WRITEBACK` parameter selects how the address is formed. `LINE_WORDS` and `CACHE_BYTES` set the geometry.

Top module: `dcache_line_maint`

## Requirements
- R1: With `cmd_user` set, the command writes no memory word, sends no external request and leaves the entry unchanged. In its final cycle it raises `exc_valid` with `exc_code` = 5'b00111.
- R2: With `WRITEBACK`=1, the target address is `op_a & op_b` when both `cmd_match_only` and `cmd_and_sel` are 1. In every other case it is `op_a + op_b`, modulo 2^32.
- R3: With `WRITEBACK`=0, the target address is `op_a` when `cmd_ext` is 0 and `op_a + op_b` when `cmd_ext` is 1.
- R4: The line index is the target address shifted right by log2(4·`LINE_WORDS`), modulo the number of lines. The line base is the target address with those low bits cleared. With the defaults (8 words, 1024 bytes) the index is bits [9:5].
- R5: When `cmd_ext`=0, `cmd_wb`=1 and the entry is dirty, each word i whose valid bit (bit i of the valid mask) is set goes to memory. Word i is written at base + 4·i with its stored data, in ascending i, and invalid words are skipped.
- R6: No memory write happens when the entry is clean, when `cmd_wb`=0 or when `cmd_ext`=1.
- R7: With `cmd_match_only`=0 the indexed entry is wiped (tag, dirty flag and valid mask become 0). With `cmd_match_only`=1 it is wiped only if its stored tag equals the line base.
- R8: With `cmd_ext`=1, `ext_req_valid` pulses in the final cycle with `ext_req_addr` equal to the target address. `ext_req_flush` equals `cmd_wb` (1 = flush, 0 = invalidate).
- R9: `busy` rises on the edge that accepts a command and `done` pulses in its last busy cycle. A command with no write-back is busy for 2 cycles. A flush is busy for 2 cycles plus one cycle for each cycle spent in the write phase.
- R10: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold.
- R11: After a write-back the entry's dirty flag is cleared even if its tag is kept, so a repeated flush of that line writes nothing.
- R12: After reset the block is idle with empty entries. A command is accepted only when `busy` is low, and `cmd_valid` held during a command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| op_a | input | XLEN | First operand |
| op_b | input | XLEN | Second operand |
| cmd_match_only | input | 1 | Invalidate only on a tag match; also selects AND addressing |
| cmd_and_sel | input | 1 | AND-address select |
| cmd_ext | input | 1 | Forward the command to the outer cache |
| cmd_wb | input | 1 | Write back (flush) rather than discard |
| cmd_user | input | 1 | Command issued in user mode |
| busy | output | 1 | Command in progress |
| done | output | 1 | Final-cycle pulse |
| exc_valid | output | 1 | Privileged-instruction exception |
| exc_code | output | 5 | Exception code |
| mem_wr_valid | output | 1 | Memory word write valid |
| mem_wr_ready | input | 1 | Memory word write ready |
| mem_wr_addr | output | XLEN | Memory word address |
| mem_wr_data | output | XLEN | Memory word data |
| ext_req_valid | output | 1 | Outer-cache request pulse |
| ext_req_flush | output | 1 | 1 = flush, 0 = invalidate |
| ext_req_addr | output | XLEN | Outer-cache request address |
| fill_en | input | 1 | Load one entry |
| fill_idx | input | IDX_W | Entry to load |
| fill_tag | input | XLEN | Stored line address |
| fill_dirty | input | 1 | Stored dirty flag |
| fill_vmask | input | LINE_WORDS | Stored per-word valid mask |
| fill_data | input | LINE_WORDS·XLEN | Line data, word i at bits [32i +: 32] |
| probe_idx | input | IDX_W | Entry to inspect |
| probe_tag | output | XLEN | Inspected tag |
| probe_dirty | output | 1 | Inspected dirty flag |
| probe_vmask | output | LINE_WORDS | Inspected valid mask |

## Verification
A wrong index or base shows up directly in the write addresses and in which probed entry changes, visible one cycle after `done`. A wrongly formed target address shows on `ext_req_addr` in the second cycle of the command. A wrong remaining-word mask shows as missing, repeated or misordered writes, or as a wrong busy length. A dirty flag that is not cleared stays hidden until the next flush of the same line, which then writes again. A wrong handshake state shows as an address or data change during a stall.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WB,
      ST_DONE
   } dlm_state_e;

   typedef struct packed {
      logic match_only;
      logic and_sel;
      logic ext;
      logic wb;
      logic user;
   } dlm_flags_t;

   localparam logic [4:0] EXC_PRIV = 5'b00111;
endpackage

// File: rtl/dlm_addr_gen.sv
module dlm_addr_gen #(
   parameter int XLEN      = 32,
   parameter int WRITEBACK = 1,
   parameter int OFF_W     = 5,
   parameter int IDX_W     = 5
) (
   input  logic [XLEN-1:0]   op_a,
   input  logic [XLEN-1:0]   op_b,
   input  dlm_pkg::dlm_flags_t flg,
   output logic [XLEN-1:0]   tgt_addr,
   output logic [IDX_W-1:0]  line_idx,
   output logic [XLEN-1:0]   line_base
);
   generate
      if (WRITEBACK != 0) begin : g_wb_addr
         always_comb begin
            if (flg.match_only && flg.and_sel) tgt_addr = op_a & op_b;
            else                               tgt_addr = op_a + op_b;
         end
      end else begin : g_wt_addr
         always_comb begin
            if (flg.ext) tgt_addr = op_a + op_b;
            else         tgt_addr = op_a;
         end
      end
   endgenerate

   assign line_idx  = tgt_addr[OFF_W +: IDX_W];
   assign line_base = {tgt_addr[XLEN-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/dlm_first_set.sv
module dlm_first_set #(
   parameter int N = 8,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] mask,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/dlm_line_store.sv
module dlm_line_store #(
   parameter int XLEN       = 32,
   parameter int LINE_WORDS = 8,
   parameter int NUM_LINES  = 32,
   localparam int IDX_W     = $clog2(NUM_LINES),
   localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fill_en,
   input  logic [IDX_W-1:0]           fill_idx,
   input  logic [XLEN-1:0]            fill_tag,
   input  logic                       fill_dirty,
   input  logic [LINE_WORDS-1:0]      fill_vmask,
   input  logic [LINE_WORDS*XLEN-1:0] fill_data,
   input  logic [IDX_W-1:0]           rd_idx,
   input  logic [WSEL_W-1:0]          rd_wsel,
   output logic [XLEN-1:0]            rd_tag,
   output logic                       rd_dirty,
   output logic [LINE_WORDS-1:0]      rd_vmask,
   output logic [XLEN-1:0]            rd_word,
   input  logic [IDX_W-1:0]           pr_idx,
   output logic [XLEN-1:0]            pr_tag,
   output logic                       pr_dirty,
   output logic [LINE_WORDS-1:0]      pr_vmask,
   input  logic                       wipe_en,
   input  logic                       clean_en
);
   logic [XLEN-1:0]       tag_q   [NUM_LINES];
   logic [NUM_LINES-1:0]  dirty_q;
   logic [LINE_WORDS-1:0] vmask_q [NUM_LINES];
   logic [XLEN-1:0]       data_q  [NUM_LINES][LINE_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LINES; i++) begin
            tag_q[i]   <= '0;
            vmask_q[i] <= '0;
         end
         dirty_q <= '0;
      end else begin
         if (clean_en) dirty_q[rd_idx] <= 1'b0;
         if (wipe_en) begin
            tag_q[rd_idx]   <= '0;
            dirty_q[rd_idx] <= 1'b0;
            vmask_q[rd_idx] <= '0;
         end
         if (fill_en) begin
            tag_q[fill_idx]   <= fill_tag;
            dirty_q[fill_idx] <= fill_dirty;
            vmask_q[fill_idx] <= fill_vmask;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         for (int w = 0; w < LINE_WORDS; w++) begin
            data_q[fill_idx][w] <= fill_data[w*XLEN +: XLEN];
         end
      end
   end

   assign rd_tag   = tag_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_vmask = vmask_q[rd_idx];
   assign rd_word  = data_q[rd_idx][rd_wsel];
   assign pr_tag   = tag_q[pr_idx];
   assign pr_dirty = dirty_q[pr_idx];
   assign pr_vmask = vmask_q[pr_idx];
endmodule

// File: rtl/dcache_line_maint.sv
module dcache_line_maint #(
   parameter int XLEN        = 32,
   parameter int WRITEBACK   = 1,
   parameter int LINE_WORDS  = 8,
   parameter int CACHE_BYTES = 1024,
   localparam int LINE_BYTES = LINE_WORDS * 4,
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int NUM_LINES  = CACHE_BYTES / LINE_BYTES,
   localparam int IDX_W      = $clog2(NUM_LINES),
   localparam int WSEL_W     = $clog2(LINE_WORDS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [XLEN-1:0]            op_a,
   input  logic [XLEN-1:0]            op_b,
   input  logic                       cmd_match_only,
   input  logic                       cmd_and_sel,
   input  logic                       cmd_ext,
   input  logic                       cmd_wb,
   input  logic                       cmd_user,
   output logic                       busy,
   output logic                       done,
   output logic                       exc_valid,
   output logic [4:0]                 exc_code,
   output logic                       mem_wr_valid,
   input  logic                       mem_wr_ready,
   output logic [XLEN-1:0]            mem_wr_addr,
   output logic [XLEN-1:0]            mem_wr_data,
   output logic                       ext_req_valid,
   output logic                       ext_req_flush,
   output logic [XLEN-1:0]            ext_req_addr,
   input  logic                       fill_en,
   input  logic [IDX_W-1:0]           fill_idx,
   input  logic [XLEN-1:0]            fill_tag,
   input  logic                       fill_dirty,
   input  logic [LINE_WORDS-1:0]      fill_vmask,
   input  logic [LINE_WORDS*XLEN-1:0] fill_data,
   input  logic [IDX_W-1:0]           probe_idx,
   output logic [XLEN-1:0]            probe_tag,
   output logic                       probe_dirty,
   output logic [LINE_WORDS-1:0]      probe_vmask
);
   import dlm_pkg::*;

   generate
      if (LINE_WORDS != 4 && LINE_WORDS != 8 && LINE_WORDS != 16) begin : g_bad_line
         $error("LINE_WORDS must be 4, 8 or 16");
      end
      if (WRITEBACK != 0 && WRITEBACK != 1) begin : g_bad_mode
         $error("WRITEBACK must be 0 or 1");
      end
      if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES || NUM_LINES * LINE_BYTES != CACHE_BYTES) begin : g_bad_size
         $error("CACHE_BYTES must be a power-of-two multiple of two lines");
      end
      if (XLEN < OFF_W + IDX_W) begin : g_bad_xlen
         $error("XLEN too narrow for index and offset");
      end
   endgenerate

   dlm_state_e            state_q;
   logic [XLEN-1:0]       op_a_q, op_b_q;
   dlm_flags_t            flg_q;
   logic [LINE_WORDS-1:0] remain_q, remain_nxt;
   logic                  wrote_q;

   logic [XLEN-1:0]       tgt_addr, line_base;
   logic [IDX_W-1:0]      line_idx;
   logic [XLEN-1:0]       rd_tag, rd_word;
   logic                  rd_dirty;
   logic [LINE_WORDS-1:0] rd_vmask;
   logic [WSEL_W-1:0]     first_idx;
   logic                  flush_hit, clr_cond, wipe_en, clean_en;

   dlm_addr_gen #(
      .XLEN(XLEN), .WRITEBACK(WRITEBACK), .OFF_W(OFF_W), .IDX_W(IDX_W)
   ) addr_i (
      .op_a(op_a_q), .op_b(op_b_q), .flg(flg_q),
      .tgt_addr(tgt_addr), .line_idx(line_idx), .line_base(line_base)
   );

   dlm_first_set #(.N(LINE_WORDS)) pick_i (
      .mask(remain_q), .idx(first_idx)
   );

   dlm_line_store #(
      .XLEN(XLEN), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
   ) store_i (
      .clk(clk), .rst_n(rst_n),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
      .fill_dirty(fill_dirty), .fill_vmask(fill_vmask), .fill_data(fill_data),
      .rd_idx(line_idx), .rd_wsel(first_idx),
      .rd_tag(rd_tag), .rd_dirty(rd_dirty), .rd_vmask(rd_vmask), .rd_word(rd_word),
      .pr_idx(probe_idx), .pr_tag(probe_tag), .pr_dirty(probe_dirty), .pr_vmask(probe_vmask),
      .wipe_en(wipe_en), .clean_en(clean_en)
   );

   always_comb begin
      remain_nxt = remain_q;
      remain_nxt[first_idx] = 1'b0;
   end

   assign flush_hit = !flg_q.user && !flg_q.ext && flg_q.wb && rd_dirty;
   assign clr_cond  = !flg_q.match_only || (rd_tag == line_base);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_a_q   <= '0;
         op_b_q   <= '0;
         flg_q    <= '0;
         remain_q <= '0;
         wrote_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_a_q  <= op_a;
                  op_b_q  <= op_b;
                  flg_q   <= '{match_only: cmd_match_only, and_sel: cmd_and_sel,
                               ext: cmd_ext, wb: cmd_wb, user: cmd_user};
                  wrote_q <= 1'b0;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               wrote_q <= flush_hit;
               if (flush_hit && (|rd_vmask)) begin
                  remain_q <= rd_vmask;
                  state_q  <= ST_WB;
               end else begin
                  state_q <= ST_DONE;
               end
            end
            ST_WB: begin
               if (mem_wr_ready) begin
                  remain_q <= remain_nxt;
                  if (remain_nxt == '0) state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);
   assign wipe_en  = done && !flg_q.user && clr_cond;
   assign clean_en = done && wrote_q;

   assign mem_wr_valid = (state_q == ST_WB);
   assign mem_wr_addr  = line_base | {{(XLEN-WSEL_W-2){1'b0}}, first_idx, 2'b00};
   assign mem_wr_data  = rd_word;

   assign ext_req_valid = done && !flg_q.user && flg_q.ext;
   assign ext_req_flush = flg_q.wb;
   assign ext_req_addr  = tgt_addr;

   assign exc_valid = done && flg_q.user;
   assign exc_code  = exc_valid ? EXC_PRIV : 5'b00000;
endmodule

// File: rtl/dlm_chk.sv
module dlm_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic            busy,
   input logic            done,
   input logic            exc_valid,
   input logic [4:0]      exc_code,
   input logic            mem_wr_valid,
   input logic            mem_wr_ready,
   input logic [XLEN-1:0] mem_wr_addr,
   input logic [XLEN-1:0] mem_wr_data,
   input logic            ext_req_valid
);
   // R9
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R9
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R12
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> busy);

   // R10
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

   // R1
   exc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (exc_code == 5'b00111 && done && !ext_req_valid));

   // R8
   ext_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req_valid |-> (done && !mem_wr_valid));

   // R5
   wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (mem_wr_addr[1:0] == 2'b00 && busy && !done));
endmodule

bind dcache_line_maint dlm_chk #(.XLEN(XLEN)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
   .exc_valid(exc_valid), .exc_code(exc_code), .mem_wr_valid(mem_wr_valid),
   .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
   .ext_req_valid(ext_req_valid)
);

// File: tb/dcache_line_maint_tb_top.sv
`timescale 1ns/100ps
module dcache_line_maint_tb_top;
   localparam int XLEN = 32;
   localparam int LW   = 8;
   localparam int IW   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            cmd_valid = 0, wt_cmd_valid = 0;
   logic [XLEN-1:0] op_a = 0, op_b = 0;
   logic            c_t = 0, c_ea = 0, c_e = 0, c_f = 0, c_um = 0;
   logic            mem_wr_ready = 1;
   logic            fill_en = 0;
   logic [IW-1:0]   fill_idx = 0;
   logic [XLEN-1:0] fill_tag = 0;
   logic            fill_dirty = 0;
   logic [LW-1:0]   fill_vmask = 0;
   logic [LW*XLEN-1:0] fill_data = 0;
   logic [IW-1:0]   probe_idx = 0;

   logic a_busy, a_done, a_exc, a_wv, a_ext, a_extf, a_pd;
   logic [4:0] a_code;
   logic [XLEN-1:0] a_wa, a_wd, a_exta, a_pt;
   logic [LW-1:0] a_pv;
   logic b_busy, b_done, b_exc, b_wv, b_ext, b_extf, b_pd;
   logic [4:0] b_code;
   logic [XLEN-1:0] b_wa, b_wd, b_exta, b_pt;
   logic [LW-1:0] b_pv;

   dcache_line_maint #(.WRITEBACK(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op_a(op_a), .op_b(op_b),
      .cmd_match_only(c_t), .cmd_and_sel(c_ea), .cmd_ext(c_e), .cmd_wb(c_f), .cmd_user(c_um),
      .busy(a_busy), .done(a_done), .exc_valid(a_exc), .exc_code(a_code),
      .mem_wr_valid(a_wv), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(a_wa), .mem_wr_data(a_wd),
      .ext_req_valid(a_ext), .ext_req_flush(a_extf), .ext_req_addr(a_exta),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
      .fill_vmask(fill_vmask), .fill_data(fill_data),
      .probe_idx(probe_idx), .probe_tag(a_pt), .probe_dirty(a_pd), .probe_vmask(a_pv));

   dcache_line_maint #(.WRITEBACK(0)) dut_wt_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(wt_cmd_valid), .op_a(op_a), .op_b(op_b),
      .cmd_match_only(c_t), .cmd_and_sel(c_ea), .cmd_ext(c_e), .cmd_wb(c_f), .cmd_user(c_um),
      .busy(b_busy), .done(b_done), .exc_valid(b_exc), .exc_code(b_code),
      .mem_wr_valid(b_wv), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(b_wa), .mem_wr_data(b_wd),
      .ext_req_valid(b_ext), .ext_req_flush(b_extf), .ext_req_addr(b_exta),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
      .fill_vmask(fill_vmask), .fill_data(fill_data),
      .probe_idx(probe_idx), .probe_tag(b_pt), .probe_dirty(b_pd), .probe_vmask(b_pv));

   logic use_wt = 0;
   logic m_busy, m_done, m_exc, m_wv, m_ext, m_extf;
   logic [4:0] m_code;
   logic [XLEN-1:0] m_wa, m_wd, m_exta;
   always_comb begin
      m_busy = use_wt ? b_busy : a_busy;
      m_done = use_wt ? b_done : a_done;
      m_exc  = use_wt ? b_exc  : a_exc;
      m_code = use_wt ? b_code : a_code;
      m_wv   = use_wt ? b_wv   : a_wv;
      m_wa   = use_wt ? b_wa   : a_wa;
      m_wd   = use_wt ? b_wd   : a_wd;
      m_ext  = use_wt ? b_ext  : a_ext;
      m_extf = use_wt ? b_extf : a_extf;
      m_exta = use_wt ? b_exta : a_exta;
   end

   int checks = 0, errors = 0, wd = 0;

   int r_cycles, r_nwr, r_ext, r_exc, r_dones, r_stall_bad;
   logic [XLEN-1:0] r_wa [16];
   logic [XLEN-1:0] r_wd [16];
   logic [XLEN-1:0] r_exta;
   logic r_extf;
   logic [4:0] r_code;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic        t;
      logic        ea;
      logic        f;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{32'h0000_1234, 32'h0000_0010, 1'b1, 1'b1, 1'b1, 32'h0000_0010},
      '{32'hF0F0_00FF, 32'h0FF0_0F0F, 1'b1, 1'b1, 1'b0, 32'h00F0_000F},
      '{32'h0000_1000, 32'h0000_0234, 1'b1, 1'b0, 1'b1, 32'h0000_1234},
      '{32'h8000_0000, 32'h8000_0004, 1'b0, 1'b1, 1'b0, 32'h0000_0004},
      '{32'hFFFF_FFF0, 32'h0000_0020, 1'b0, 1'b0, 1'b1, 32'h0000_0010}
   };

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic fill(input logic [IW-1:0] idx, input logic [31:0] tag, input logic dirty,
                       input logic [LW-1:0] vm, input logic [31:0] seed);
      @(negedge clk);
      fill_en = 1; fill_idx = idx; fill_tag = tag; fill_dirty = dirty; fill_vmask = vm;
      for (int w = 0; w < LW; w++) fill_data[w*32 +: 32] = seed + 32'(w);
      @(negedge clk);
      fill_en = 0;
   endtask

   task automatic run_cmd(input logic wt, input logic [31:0] a, input logic [31:0] b,
                          input logic t, input logic ea, input logic e, input logic f,
                          input logic um, input int hold, input int rmode);
      int cyc, post;
      logic fin, prev_stall;
      logic [31:0] pa, pd;
      @(negedge clk);
      use_wt = wt;
      op_a = a; op_b = b; c_t = t; c_ea = ea; c_e = e; c_f = f; c_um = um;
      if (wt) wt_cmd_valid = 1; else cmd_valid = 1;
      r_cycles = 0; r_nwr = 0; r_ext = 0; r_exc = 0; r_dones = 0; r_stall_bad = 0;
      r_exta = 0; r_extf = 0; r_code = 0;
      cyc = 0; post = 0; fin = 0; prev_stall = 0; pa = 0; pd = 0;
      @(posedge clk);
      while (!(fin && post >= 3) && cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (cyc >= hold) begin cmd_valid = 0; wt_cmd_valid = 0; end
         mem_wr_ready = (rmode == 0) || cyc[0];
         if (fin) post++;
         if (m_busy) r_cycles++;
         if (prev_stall && (!m_wv || m_wa !== pa || m_wd !== pd)) r_stall_bad++;
         prev_stall = m_wv && !mem_wr_ready;
         pa = m_wa; pd = m_wd;
         if (m_wv && mem_wr_ready) begin
            if (r_nwr < 16) begin r_wa[r_nwr] = m_wa; r_wd[r_nwr] = m_wd; end
            r_nwr++;
         end
         if (m_ext) begin r_ext++; r_exta = m_exta; r_extf = m_extf; end
         if (m_exc) begin r_exc++; r_code = m_code; end
         if (m_done) begin r_dones++; fin = 1; end
      end
      mem_wr_ready = 1;
   endtask

   task automatic probe(input logic [IW-1:0] idx);
      @(negedge clk);
      probe_idx = idx;
      #1;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         errors++;
         $display("FAIL R9 watchdog actual=%0d expected<20000", wd);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      check("R12", "busy after reset", a_busy, 0);
      check("R12", "done after reset", a_done, 0);
      check("R12", "mem_wr_valid after reset", a_wv, 0);
      check("R12", "ext_req_valid after reset", a_ext, 0);
      probe(3);
      check("R12", "empty tag after reset", a_pt, 0);
      check("R12", "empty vmask after reset", a_pv, 0);

      // R2 R8 R9: vector table, external requests
      for (int i = 0; i < 5; i++) begin
         run_cmd(0, VECS[i].a, VECS[i].b, VECS[i].t, VECS[i].ea, 1, VECS[i].f, 0, 1, 0);
         check("R2", "ext address", r_exta, VECS[i].exp);
         check("R8", "ext request count", r_ext, 1);
         check("R8", "ext flush flag", r_extf, VECS[i].f);
         check("R6", "no writes when external", r_nwr, 0);
         check("R9", "busy cycles invalidate", r_cycles, 2);
      end

      // R5 R4 R7 R9: flush with gaps in valid mask, line 3
      fill(3, 32'h0000_2060, 1, 8'b1010_0101, 32'hD000_0000);
      run_cmd(0, 32'h0000_2000, 32'h0000_0074, 0, 0, 0, 1, 0, 1, 0);
      check("R5", "write count", r_nwr, 4);
      check("R5", "addr w0", r_wa[0], 32'h0000_2060);
      check("R5", "addr w2", r_wa[1], 32'h0000_2068);
      check("R5", "addr w5", r_wa[2], 32'h0000_2074);
      check("R5", "addr w7", r_wa[3], 32'h0000_207C);
      check("R5", "data w0", r_wd[0], 32'hD000_0000);
      check("R5", "data w2", r_wd[1], 32'hD000_0002);
      check("R5", "data w5", r_wd[2], 32'hD000_0005);
      check("R5", "data w7", r_wd[3], 32'hD000_0007);
      check("R9", "flush busy cycles", r_cycles, 6);
      probe(3);
      check("R7", "unconditional wipe tag", a_pt, 0);
      check("R7", "unconditional wipe vmask", a_pv, 0);
      check("R4", "wipe dirty", a_pd, 0);

      // R10 R11 R7 R4: stalled flush, tag mismatch keeps tag, line 5
      fill(5, 32'h0000_40A0, 1, 8'h03, 32'hA500_0000);
      run_cmd(0, 32'h0000_80A0, 32'h0, 1, 0, 0, 1, 0, 1, 1);
      check("R10", "stall stability", r_stall_bad, 0);
      check("R10", "stalled write count", r_nwr, 2);
      check("R4", "base from target addr", r_wa[0], 32'h0000_80A0);
      check("R10", "second word addr", r_wa[1], 32'h0000_80A4);
      check("R10", "second word data", r_wd[1], 32'hA500_0001);
      check("R9", "stalled busy cycles", r_cycles, 6);
      probe(5);
      check("R7", "mismatch keeps tag", a_pt, 32'h0000_40A0);
      check("R11", "dirty cleared after write-back", a_pd, 0);
      run_cmd(0, 32'h0000_80A0, 32'h0, 1, 0, 0, 1, 0, 1, 0);
      check("R11", "repeat flush writes", r_nwr, 0);
      check("R11", "repeat flush cycles", r_cycles, 2);

      // R6 R7: match-only invalidate without write-back, line 7
      fill(7, 32'h0000_00E0, 1, 8'hFF, 32'h7700_0000);
      run_cmd(0, 32'h0000_00E4, 32'h0, 1, 0, 0, 0, 0, 1, 0);
      check("R6", "invalidate writes", r_nwr, 0);
      check("R9", "invalidate cycles", r_cycles, 2);
      probe(7);
      check("R7", "match wipes tag", a_pt, 0);
      check("R7", "match wipes dirty", a_pd, 0);

      // R6: clean line flush, line 9
      fill(9, 32'h0000_0120, 0, 8'hFF, 32'h9900_0000);
      run_cmd(0, 32'h0000_0120, 32'h0, 0, 0, 0, 1, 0, 1, 0);
      check("R6", "clean line writes", r_nwr, 0);

      // R1: user mode, line 11
      fill(11, 32'h0000_0160, 1, 8'h01, 32'hBB00_0000);
      run_cmd(0, 32'h0000_0160, 32'h0, 0, 0, 0, 1, 1, 1, 0);
      check("R1", "exception count", r_exc, 1);
      check("R1", "exception code", r_code, 5'b00111);
      check("R1", "user writes", r_nwr, 0);
      check("R1", "user ext requests", r_ext, 0);
      check("R1", "user cycles", r_cycles, 2);
      probe(11);
      check("R1", "tag untouched", a_pt, 32'h0000_0160);
      check("R1", "dirty untouched", a_pd, 1);
      check("R1", "vmask untouched", a_pv, 8'h01);

      // R12: cmd_valid held while busy
      run_cmd(0, 32'h0000_0300, 32'h4, 0, 0, 1, 0, 0, 2, 0);
      check("R12", "single done", r_dones, 1);
      check("R12", "single ext request", r_ext, 1);
      check("R12", "busy cycles with held valid", r_cycles, 2);

      // R3: write-through instance
      run_cmd(1, 32'h0000_0100, 32'h0000_0024, 1, 1, 1, 1, 0, 1, 0);
      check("R3", "external address adds", r_exta, 32'h0000_0124);
      fill(15, 32'h0000_01E0, 1, 8'h01, 32'hCC00_0000);
      run_cmd(1, 32'h0000_01E0, 32'h0000_0400, 0, 0, 0, 1, 0, 1, 0);
      check("R3", "write-through flush count", r_nwr, 1);
      check("R3", "address is op_a alone", r_wa[0], 32'h0000_01E0);
      check("R3", "write data", r_wd[0], 32'hCC00_0000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule